// File: doc/BRIEF.md
# Indexed RGBI Color Palette

This block is a 16-entry color lookup table placed between the pixel generator and the display output. Each entry is 4 bits wide: blue, green, red and intensity. The host reaches the table indirectly, through two write strobes that share one host data bus. A write on the index strobe loads the index register. A write on the data strobe then stores a color into the entry that the index names. Indices 0x10 to 0x1F select the palette window.

During active display the block forms a 4-bit lookup index from the incoming pixel code. In reduced-color graphics modes, the pixel supplies only its low bits and the mode's extra bits fill the rest. A mask control can then clear the upper index bits. The registered lookup result drives the output, which reads 0000 during blanking. While the host holds the palette window selected, the output shows the last written data value instead of the lookup result. This models the visible disturbance on the screen.

Top module: `rgbi_palette`

## Requirements
- R1: After reset the index register is 0, the output register is 0000, and entry n holds the value n, so in 16-color mode with no mask the output equals the pixel code.
- R2: An index-strobe write loads the whole host word into the index register. The palette window is selected exactly when the index lies in 0x10..0x1F.
- R3: A data-strobe write while the window is selected stores host bits [3:0] into the entry named by index bits [3:0]. Output bit 0 is blue, bit 1 green, bit 2 red and bit 3 intensity.
- R4: A data-strobe write while the window is not selected leaves every palette entry unchanged.
- R5: Depth code 00 (and 11) is the 16-color mode: the lookup index is the pixel code. The output shows the entry one clock after the code is presented.
- R6: Depth code 01 is the 4-color mode: the lookup index is {extra[3:2], pixel[1:0]}.
- R7: Depth code 10 is the 2-color mode: the lookup index is {extra[3:1], pixel[0]}.
- R8: Mask code 01 forces index bits 3 and 2 to 0, so only entries 0..3 can be reached.
- R9: Mask code 10 forces index bits 3, 2 and 1 to 0, so only entries 0 and 1 can be reached. Mask codes 00 and 11 leave the index as formed.
- R10: While the window is selected and blank is low, the output one clock later is bits [3:0] of the most recent data-strobe write (0000 if none has happened since reset). Lookup output resumes once the index is set outside the window.
- R11: When blank is high, the output one clock later is 0000, taking priority over R10.
- R12: The index register keeps its value across data-strobe writes and idle cycles. Only an index-strobe write changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_wr | input | 1 | Host strobe that loads the index register |
| dat_wr | input | 1 | Host strobe that writes a color through the data port |
| host_wdata | input | HOST_W | Host write data shared by both strobes |
| pix_code | input | 4 | Pixel code from the pixel generator |
| mode_extra | input | 4 | Upper index bits supplied by the graphics mode |
| depth_sel | input | 2 | Color depth: 00 = 16, 01 = 4, 10 = 2, 11 = 16 |
| mask_sel | input | 2 | Index mask: 00 = none, 01 = clear bits 3:2, 10 = clear bits 3:1, 11 = none |
| blank | input | 1 | Blanking interval; forces the output to 0000 |
| rgbi_out | output | 4 | Registered color: bit 3 I, bit 2 R, bit 1 G, bit 0 B |

## Verification
The assertions assume that the host never raises both strobes in the same cycle. They also assume that the depth and mask codes hold steady for the clock edge that registers a lookup. The bench drives every input on the falling edge and pulses only one strobe per host task, so both assumptions hold throughout. The mask properties hold for any pixel code and any extra bits, so the stimulus is free to sweep those inputs.

// File: rtl/rgbi_palette_pkg.sv
package rgbi_palette_pkg;

    localparam int COLOR_W = 4;
    localparam int ENTRIES = 1 << COLOR_W;

    typedef logic [COLOR_W-1:0] rgbi_t;

    typedef enum logic [1:0] {
        DEPTH_16  = 2'b00,
        DEPTH_4   = 2'b01,
        DEPTH_2   = 2'b10,
        DEPTH_ALT = 2'b11
    } depth_e;

    typedef enum logic [1:0] {
        MASK_NONE = 2'b00,
        MASK_4C   = 2'b01,
        MASK_2C   = 2'b10,
        MASK_ALT  = 2'b11
    } mask_e;

    typedef struct packed {
        logic   blank;
        logic   disturb;
        rgbi_t  host_color;
        rgbi_t  lut_color;
    } out_sel_t;

    function automatic rgbi_t merge_index(rgbi_t pix, rgbi_t extra, depth_e depth);
        case (depth)
            DEPTH_4: return {extra[3:2], pix[1:0]};
            DEPTH_2: return {extra[3:1], pix[0]};
            default: return pix;
        endcase
    endfunction

    function automatic rgbi_t mask_index(rgbi_t idx, mask_e mask);
        case (mask)
            MASK_4C: return idx & 4'b0011;
            MASK_2C: return idx & 4'b0001;
            default: return idx;
        endcase
    endfunction

endpackage

// File: rtl/rgbi_palette_regs.sv
module rgbi_palette_regs
    import rgbi_palette_pkg::*;
#(
    parameter int HOST_W = 8,
    parameter logic INIT_IDENTITY = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        idx_wr,
    input  logic                        dat_wr,
    input  logic [HOST_W-1:0]           host_wdata,
    output logic [HOST_W-1:0]           addr_q,
    output logic                        pal_sel,
    output rgbi_t                       host_color,
    output logic [ENTRIES-1:0][COLOR_W-1:0] pal_q
);
    localparam int WIN_LSB = COLOR_W;
    localparam logic [HOST_W-WIN_LSB-1:0] WIN_TAG = 1;

    logic unused_hi;
    assign unused_hi = ^host_wdata[HOST_W-1:COLOR_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (idx_wr) begin
            addr_q <= host_wdata;
        end
    end

    assign pal_sel = (addr_q[HOST_W-1:WIN_LSB] == WIN_TAG);

    always_ff @(posedge clk) begin
        if (rst) begin
            host_color <= '0;
        end else if (dat_wr) begin
            host_color <= host_wdata[COLOR_W-1:0];
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        localparam rgbi_t RST_VAL = INIT_IDENTITY ? rgbi_t'(e) : '0;
        logic hit;
        assign hit = dat_wr && pal_sel && (addr_q[COLOR_W-1:0] == rgbi_t'(e));
        always_ff @(posedge clk) begin
            if (rst) begin
                pal_q[e] <= RST_VAL;
            end else if (hit) begin
                pal_q[e] <= host_wdata[COLOR_W-1:0];
            end
        end
    end

endmodule

// File: rtl/rgbi_palette_index.sv
module rgbi_palette_index
    import rgbi_palette_pkg::*;
(
    input  rgbi_t       pix_code,
    input  rgbi_t       mode_extra,
    input  logic [1:0]  depth_sel,
    input  logic [1:0]  mask_sel,
    output rgbi_t       lut_idx
);
    rgbi_t merged;

    always_comb begin
        merged  = merge_index(pix_code, mode_extra, depth_e'(depth_sel));
        lut_idx = mask_index(merged, mask_e'(mask_sel));
    end

endmodule

// File: rtl/rgbi_palette_outmux.sv
module rgbi_palette_outmux
    import rgbi_palette_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  out_sel_t sel_in,
    output rgbi_t    rgbi_out
);
    rgbi_t nxt;

    always_comb begin
        if (sel_in.blank) begin
            nxt = '0;
        end else if (sel_in.disturb) begin
            nxt = sel_in.host_color;
        end else begin
            nxt = sel_in.lut_color;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rgbi_out <= '0;
        end else begin
            rgbi_out <= nxt;
        end
    end

endmodule

// File: rtl/rgbi_palette.sv
module rgbi_palette
    import rgbi_palette_pkg::*;
#(
    parameter int HOST_W = 8,
    parameter logic INIT_IDENTITY = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idx_wr,
    input  logic              dat_wr,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic [3:0]        pix_code,
    input  logic [3:0]        mode_extra,
    input  logic [1:0]        depth_sel,
    input  logic [1:0]        mask_sel,
    input  logic              blank,
    output logic [3:0]        rgbi_out
);
    logic [HOST_W-1:0]                addr_q;
    logic                             pal_sel;
    rgbi_t                            host_color;
    logic [ENTRIES-1:0][COLOR_W-1:0]  pal_q;
    rgbi_t                            lut_idx;
    out_sel_t                         osel;

    rgbi_palette_regs #(
        .HOST_W        (HOST_W),
        .INIT_IDENTITY (INIT_IDENTITY)
    ) regs_i (
        .clk        (clk),
        .rst        (rst),
        .idx_wr     (idx_wr),
        .dat_wr     (dat_wr),
        .host_wdata (host_wdata),
        .addr_q     (addr_q),
        .pal_sel    (pal_sel),
        .host_color (host_color),
        .pal_q      (pal_q)
    );

    rgbi_palette_index index_i (
        .pix_code   (pix_code),
        .mode_extra (mode_extra),
        .depth_sel  (depth_sel),
        .mask_sel   (mask_sel),
        .lut_idx    (lut_idx)
    );

    always_comb begin
        osel.blank      = blank;
        osel.disturb    = pal_sel;
        osel.host_color = host_color;
        osel.lut_color  = pal_q[lut_idx];
    end

    rgbi_palette_outmux outmux_i (
        .clk      (clk),
        .rst      (rst),
        .sel_in   (osel),
        .rgbi_out (rgbi_out)
    );

endmodule

// File: rtl/rgbi_palette_chk.sv
module rgbi_palette_chk #(
    parameter int HOST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idx_wr,
    input  logic              blank,
    input  logic [1:0]        mask_sel,
    input  logic [3:0]        lut_idx,
    input  logic              pal_sel,
    input  logic [3:0]        host_color,
    input  logic [HOST_W-1:0] addr_q,
    input  logic [3:0]        rgbi_out
);
    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (rst)
        blank |=> (rgbi_out == 4'b0000)); // R11

    AST_DISTURB_SHOWS_HOST: assert property (@(posedge clk) disable iff (rst)
        (!blank && pal_sel) |=> (rgbi_out == $past(host_color))); // R10

    AST_MASK_FOUR: assert property (@(posedge clk) disable iff (rst)
        (mask_sel == 2'b01) |-> (lut_idx[3:2] == 2'b00)); // R8

    AST_MASK_TWO: assert property (@(posedge clk) disable iff (rst)
        (mask_sel == 2'b10) |-> (lut_idx[3:1] == 3'b000)); // R9

    AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !idx_wr |=> $stable(addr_q)); // R12

endmodule

bind rgbi_palette rgbi_palette_chk #(.HOST_W(HOST_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .idx_wr     (idx_wr),
    .blank      (blank),
    .mask_sel   (mask_sel),
    .lut_idx    (lut_idx),
    .pal_sel    (pal_sel),
    .host_color (host_color),
    .addr_q     (addr_q),
    .rgbi_out   (rgbi_out)
);

// File: tb/rgbi_palette_tb.sv
`timescale 1ns/1ps
module rgbi_palette_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       idx_wr;
    logic       dat_wr;
    logic [7:0] host_wdata;
    logic [3:0] pix_code;
    logic [3:0] mode_extra;
    logic [1:0] depth_sel;
    logic [1:0] mask_sel;
    logic       blank;
    logic [3:0] rgbi_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [3:0] m_pal [16];
    logic [7:0] m_addr;
    logic [3:0] m_data;

    always #2.5 clk = ~clk;

    rgbi_palette #(.HOST_W(8), .INIT_IDENTITY(1'b1)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .idx_wr     (idx_wr),
        .dat_wr     (dat_wr),
        .host_wdata (host_wdata),
        .pix_code   (pix_code),
        .mode_extra (mode_extra),
        .depth_sel  (depth_sel),
        .mask_sel   (mask_sel),
        .blank      (blank),
        .rgbi_out   (rgbi_out)
    );

    function automatic logic [3:0] expect_out(logic [3:0] p, logic [3:0] x,
                                              logic [1:0] d, logic [1:0] m, logic b);
        logic [3:0] i;
        case (d)
            2'b01:   i = {x[3:2], p[1:0]};
            2'b10:   i = {x[3:1], p[0]};
            default: i = p;
        endcase
        if (m == 2'b01) i = {2'b00, i[1:0]};
        else if (m == 2'b10) i = {3'b000, i[0]};
        if (b) return 4'b0000;
        if (m_addr >= 8'h10 && m_addr <= 8'h1F) return m_data;
        return m_pal[i];
    endfunction

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_index(logic [7:0] v);
        @(negedge clk);
        idx_wr = 1'b1; host_wdata = v;
        @(negedge clk);
        idx_wr = 1'b0;
        m_addr = v;
    endtask

    task automatic host_data(logic [7:0] v);
        @(negedge clk);
        dat_wr = 1'b1; host_wdata = v;
        @(negedge clk);
        dat_wr = 1'b0;
        m_data = v[3:0];
        if (m_addr >= 8'h10 && m_addr <= 8'h1F) m_pal[m_addr[3:0]] = v[3:0];
    endtask

    task automatic look(string req, logic [3:0] p, logic [3:0] x,
                        logic [1:0] d, logic [1:0] m, logic b);
        @(negedge clk);
        pix_code = p; mode_extra = x; depth_sel = d; mask_sel = m; blank = b;
        @(negedge clk);
        check(req, rgbi_out, expect_out(p, x, d, m, b));
    endtask

    task automatic t_reset;
        check("R1 reset output", rgbi_out, 4'b0000);
        for (int k = 0; k < 16; k++) look("R1 R5 identity", 4'(k), 4'h0, 2'b00, 2'b00, 1'b0);
        look("R5 alt depth code", 4'h9, 4'h0, 2'b11, 2'b00, 1'b0);
    endtask

    task automatic t_write;
        host_index(8'h13);
        look("R10 disturb reset data", 4'h7, 4'h0, 2'b00, 2'b00, 1'b0);
        host_data(8'hA5);
        look("R10 disturb shows data", 4'h2, 4'h0, 2'b00, 2'b00, 1'b0);
        look("R11 blank over disturb", 4'h2, 4'h0, 2'b00, 2'b00, 1'b1);
        host_index(8'h1C);
        host_data(8'h0B);
        host_index(8'h05);
        look("R3 entry 3 written", 4'h3, 4'h0, 2'b00, 2'b00, 1'b0);
        look("R3 entry C written", 4'hC, 4'h0, 2'b00, 2'b00, 1'b0);
        host_data(8'h0E);
        for (int k = 0; k < 16; k++) look("R4 ignored write", 4'(k), 4'h0, 2'b00, 2'b00, 1'b0);
        host_index(8'h20);
        look("R2 index outside window", 4'hC, 4'h0, 2'b00, 2'b00, 1'b0);
        host_index(8'h0F);
        look("R2 index below window", 4'h3, 4'h0, 2'b00, 2'b00, 1'b0);
    endtask

    task automatic t_hold;
        host_index(8'h1E);
        host_data(8'h01);
        host_data(8'h08);
        repeat (3) @(negedge clk);
        host_data(8'h06);
        host_index(8'h00);
        look("R12 index held, entry E", 4'hE, 4'h0, 2'b00, 2'b00, 1'b0);
        look("R12 entry F untouched", 4'hF, 4'h0, 2'b00, 2'b00, 1'b0);
    endtask

    task automatic t_modes;
        for (int k = 0; k < 4; k++) look("R6 four color", 4'(k) | 4'hC, 4'h8, 2'b01, 2'b00, 1'b0);
        look("R6 four color extra", 4'h1, 4'hC, 2'b01, 2'b00, 1'b0);
        look("R7 two color", 4'hE, 4'h6, 2'b10, 2'b00, 1'b0);
        look("R7 two color", 4'h1, 4'hE, 2'b10, 2'b00, 1'b0);
    endtask

    task automatic t_mask;
        look("R8 mask four", 4'hF, 4'h0, 2'b00, 2'b01, 1'b0);
        look("R8 mask four extra", 4'h2, 4'hC, 2'b01, 2'b01, 1'b0);
        look("R9 mask two", 4'hF, 4'h0, 2'b00, 2'b10, 1'b0);
        look("R9 mask two extra", 4'h0, 4'hE, 2'b10, 2'b10, 1'b0);
        look("R9 mask code 11 none", 4'hC, 4'h0, 2'b00, 2'b11, 1'b0);
    endtask

    task automatic t_blank;
        look("R11 blank", 4'hC, 4'h0, 2'b00, 2'b00, 1'b1);
        look("R11 after blank", 4'hC, 4'h0, 2'b00, 2'b00, 1'b0);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 16; k++) m_pal[k] = 4'(k);
        m_addr = 8'h00; m_data = 4'h0;
        rst = 1'b1; idx_wr = 1'b0; dat_wr = 1'b0; host_wdata = 8'h00;
        pix_code = 4'h0; mode_extra = 4'h0; depth_sel = 2'b00; mask_sel = 2'b00; blank = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_write;
        t_hold;
        t_modes;
        t_mask;
        t_blank;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule